// File: doc/BRIEF.md
# Bias Register Two-Wire Slave

This block is a serial slave on a two-wire bus. It gives a bus master access to three byte-wide control locations of an amplifier bias controller: an 8-bit bias tap, a 6-bit reference tap and a status register. The serial clock and data lines are oversampled by the system clock. The block drives the data line only by pulling it low, through `sdaPullLow`. The chip connects that signal to an open-drain pad.

A transfer starts with a slave byte. Its upper four bits carry a fixed device identifier and the next three bits match the hardware strap pins. A write then sends a location byte and one or more data bytes. A read returns bytes from an internal pointer, which advances after each byte. The status register combines live status inputs with a write-enable flag and a gain-select bit. While the write-enable flag is set, each write to the bias or reference tap raises a one-cycle request for the nonvolatile store engine. While that engine reports busy, the slave does not answer its slave byte, so the master can poll for completion.

Top module: `biasI2cSlave`

## Requirements
- R1: A slave byte is acknowledged only if bits 7:4 equal 0101 and bits 3:1 equal `devAddr`. Bit 0 selects read (1) or write (0). A slave byte that does not match gets no acknowledge, and the rest of that transfer is ignored.
- R2: In a write, the slave byte, the location byte and the data byte are each acknowledged by pulling SDA low during the ninth clock. The data byte updates the addressed register when its acknowledge clock ends, and `regWrStrobe` pulses high for exactly one cycle.
- R3: Location 01h keeps only data bits 5:0 in `refTap`. A read of 01h returns bits 7:6 as 0.
- R4: A stop condition that arrives before a data byte and its acknowledge clock have completed leaves every register unchanged and produces no write strobe.
- R5: While `nvBusy` is high, a slave byte is not acknowledged.
- R6: The location pointer is 0 after reset. A write with only a slave byte and a location byte loads the pointer and changes no register. Each read byte returns the location at the pointer, and the pointer then advances by one.
- R7: Reading location 0Fh returns these bits: bit7 `stShutdown`, bit6 `stDirection`, bit4 `stEnable`, bit1 write-enable flag, bit0 gain. Bits 5, 3 and 2 read as 0.
- R8: Writing location 0Fh loads the write-enable flag from data bit 1 and gain from data bit 0. Writing 02h therefore sets the flag. Both are 0 after reset.
- R9: `nvStoreReq` pulses for one cycle on a write to 00h or 01h, but only if the write-enable flag was 1 at that time. With the flag at 0, only the register values change.
- R10: After a data byte written to 0Fh, any further data byte in the same transfer is not acknowledged and has no effect.
- R11: A write to locations 02h to 0Eh, or to any location above 0Fh, is acknowledged and changes nothing. A read of such a location returns 00h.
- R12: After a data byte written to 00h or 01h, the next data byte in the same transfer goes to the following location.
- R13: A read continues while the master acknowledges each byte. After a byte that the master does not acknowledge, the slave releases SDA until the next start condition.
- R14: `sdaPullLow` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock line level |
| sda | input | 1 | Serial data line level |
| sdaPullLow | output | 1 | High pulls the data line low (open-drain drive) |
| devAddr | input | 3 | Hardware address straps |
| nvBusy | input | 1 | Nonvolatile store in progress |
| stShutdown | input | 1 | Live shutdown status |
| stDirection | input | 1 | Live comparator direction status |
| stEnable | input | 1 | Live calibration enable status |
| biasTap | output | BIAS_W | Bias tap register |
| refTap | output | REF_W | Reference tap register |
| gainSel | output | 1 | Gain select bit |
| welFlag | output | 1 | Write-enable flag for nonvolatile store |
| regWrStrobe | output | 1 | One-cycle pulse per accepted data byte |
| regRdStrobe | output | 1 | One-cycle pulse per byte loaded for reading |
| strobeAddr | output | 8 | Location of the last strobe |
| nvStoreReq | output | 1 | One-cycle request to store a tap value |

## Verification
Two events can fall into the same transfer window: a stop condition and the commit of a data byte. The bench sends a stop after only half of a data byte, and in a separate transfer sends a stop right after a complete acknowledge. The register outputs and the strobe counts must show that only the second transfer took effect. A second collision is a read byte being loaded in the same cycle that the pointer advances. The bench reads three bytes back to back from a known start location and checks that each byte comes from the next location in turn.

// File: rtl/biasI2cPkg.sv
`timescale 1ns/1ps
package biasI2cPkg;
  localparam logic [3:0] DEV_ID = 4'b0101;
  localparam logic [7:0] LOC_BIAS = 8'h00;
  localparam logic [7:0] LOC_REF = 8'h01;
  localparam logic [7:0] LOC_STAT = 8'h0F;

  typedef struct packed {
    logic       loadPtr;
    logic       wrData;
    logic       rdLoad;
    logic [7:0] byteVal;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ADDR, ST_WDAT, ST_RDAT, ST_SKIP
  } busState_t;
endpackage

// File: rtl/biasI2cCtrl.sv
`timescale 1ns/1ps
module biasI2cCtrl
  import biasI2cPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        scl,
  input  logic        sda,
  input  logic [2:0]  devAddr,
  input  logic        nvBusy,
  input  logic        ptrIsStat,
  input  logic [7:0]  rdByte,
  output logic        sdaPullLow,
  output ctrlStrobe_t strb
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], scl};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sda};
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclS && !sclP;
  assign sclFall = !sclS && sclP;
  assign startDet = sclS && sclP && sdaP && !sdaS;
  assign stopDet = sclS && sclP && !sdaP && sdaS;

  busState_t state;
  logic [3:0] bitCnt;
  logic ackPhase, pullQ, mAck, statDone, ackOk;
  logic [7:0] rxShift, txShift;

  always_comb begin
    case (state)
      ST_DEV:  ackOk = (rxShift[7:4] == DEV_ID) && (rxShift[3:1] == devAddr) && !nvBusy;
      ST_ADDR: ackOk = 1'b1;
      ST_WDAT: ackOk = !statDone;
      default: ackOk = 1'b0;
    endcase
  end

  always_comb begin
    strb = '0;
    strb.byteVal = rxShift;
    if (sclFall && ackPhase) begin
      case (state)
        ST_DEV:  strb.rdLoad = rxShift[0];
        ST_ADDR: strb.loadPtr = 1'b1;
        ST_WDAT: strb.wrData = 1'b1;
        ST_RDAT: strb.rdLoad = mAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      ackPhase <= 1'b0;
      pullQ <= 1'b0;
      mAck <= 1'b0;
      statDone <= 1'b0;
      rxShift <= '0;
      txShift <= '0;
    end else if (startDet) begin
      state <= ST_DEV;
      bitCnt <= '0;
      ackPhase <= 1'b0;
      pullQ <= 1'b0;
      statDone <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      ackPhase <= 1'b0;
      pullQ <= 1'b0;
    end else if (state == ST_IDLE || state == ST_SKIP) begin
      pullQ <= 1'b0;
    end else if (sclRise) begin
      if (ackPhase) begin
        mAck <= !sdaS;
      end else if (bitCnt < LAST_BIT) begin
        rxShift <= {rxShift[6:0], sdaS};
        bitCnt <= bitCnt + 4'd1;
      end
    end else if (sclFall) begin
      if (ackPhase) begin
        ackPhase <= 1'b0;
        bitCnt <= '0;
        pullQ <= 1'b0;
        case (state)
          ST_DEV:  state <= rxShift[0] ? ST_RDAT : ST_ADDR;
          ST_ADDR: state <= ST_WDAT;
          ST_WDAT: if (ptrIsStat) statDone <= 1'b1;
          ST_RDAT: if (!mAck) state <= ST_SKIP;
          default: ;
        endcase
        if (strb.rdLoad) begin
          txShift <= rdByte;
          pullQ <= !rdByte[7];
        end
      end else if (bitCnt == LAST_BIT) begin
        if (state == ST_RDAT) begin
          ackPhase <= 1'b1;
          pullQ <= 1'b0;
        end else if (ackOk) begin
          ackPhase <= 1'b1;
          pullQ <= 1'b1;
        end else begin
          state <= ST_SKIP;
          pullQ <= 1'b0;
        end
      end else if (state == ST_RDAT && bitCnt != 4'd0) begin
        txShift <= {txShift[6:0], 1'b0};
        pullQ <= !txShift[6];
      end
    end
  end

  assign sdaPullLow = pullQ;
endmodule

// File: rtl/biasI2cData.sv
`timescale 1ns/1ps
module biasI2cData
  import biasI2cPkg::*;
#(
  parameter int BIAS_W = 8,
  parameter int REF_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic              stShutdown,
  input  logic              stDirection,
  input  logic              stEnable,
  output logic [7:0]        rdByte,
  output logic              ptrIsStat,
  output logic [BIAS_W-1:0] biasTap,
  output logic [REF_W-1:0]  refTap,
  output logic              gainSel,
  output logic              welFlag,
  output logic              regWrStrobe,
  output logic              regRdStrobe,
  output logic [7:0]        strobeAddr,
  output logic              nvStoreReq
);
  logic [7:0] ptr;
  logic tapLoc;

  assign ptrIsStat = (ptr == LOC_STAT);
  assign tapLoc = (ptr == LOC_BIAS) || (ptr == LOC_REF);

  always_comb begin
    case (ptr)
      LOC_BIAS: rdByte = 8'(biasTap);
      LOC_REF:  rdByte = 8'(refTap);
      LOC_STAT: rdByte = {stShutdown, stDirection, 1'b0, stEnable, 2'b00, welFlag, gainSel};
      default:  rdByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      biasTap <= '0;
      refTap <= '0;
      gainSel <= 1'b0;
      welFlag <= 1'b0;
      regWrStrobe <= 1'b0;
      regRdStrobe <= 1'b0;
      strobeAddr <= '0;
      nvStoreReq <= 1'b0;
    end else begin
      regWrStrobe <= strb.wrData;
      regRdStrobe <= strb.rdLoad;
      nvStoreReq <= strb.wrData && welFlag && tapLoc;
      if (strb.wrData || strb.rdLoad) strobeAddr <= ptr;
      if (strb.loadPtr) begin
        ptr <= strb.byteVal;
      end else if (strb.rdLoad) begin
        ptr <= ptr + 8'd1;
      end else if (strb.wrData) begin
        ptr <= ptr + 8'd1;
        case (ptr)
          LOC_BIAS: biasTap <= strb.byteVal[BIAS_W-1:0];
          LOC_REF:  refTap <= strb.byteVal[REF_W-1:0];
          LOC_STAT: {welFlag, gainSel} <= strb.byteVal[1:0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/biasI2cSlave.sv
`timescale 1ns/1ps
module biasI2cSlave
  import biasI2cPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BIAS_W = 8,
  parameter int REF_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sda,
  output logic              sdaPullLow,
  input  logic [2:0]        devAddr,
  input  logic              nvBusy,
  input  logic              stShutdown,
  input  logic              stDirection,
  input  logic              stEnable,
  output logic [BIAS_W-1:0] biasTap,
  output logic [REF_W-1:0]  refTap,
  output logic              gainSel,
  output logic              welFlag,
  output logic              regWrStrobe,
  output logic              regRdStrobe,
  output logic [7:0]        strobeAddr,
  output logic              nvStoreReq
);
  ctrlStrobe_t strb;
  logic [7:0] rdByte;
  logic ptrIsStat;

  biasI2cCtrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .scl(scl), .sda(sda), .devAddr(devAddr),
    .nvBusy(nvBusy), .ptrIsStat(ptrIsStat), .rdByte(rdByte),
    .sdaPullLow(sdaPullLow), .strb(strb)
  );

  biasI2cData #(.BIAS_W(BIAS_W), .REF_W(REF_W)) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .stShutdown(stShutdown),
    .stDirection(stDirection), .stEnable(stEnable), .rdByte(rdByte),
    .ptrIsStat(ptrIsStat), .biasTap(biasTap), .refTap(refTap),
    .gainSel(gainSel), .welFlag(welFlag), .regWrStrobe(regWrStrobe),
    .regRdStrobe(regRdStrobe), .strobeAddr(strobeAddr), .nvStoreReq(nvStoreReq)
  );
endmodule

// File: rtl/biasI2cChecker.sv
`timescale 1ns/1ps
module biasI2cChecker #(
  parameter int BIAS_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              scl,
  input logic              sdaPullLow,
  input logic              welFlag,
  input logic [BIAS_W-1:0] biasTap,
  input logic              regWrStrobe,
  input logic              nvStoreReq
);
  p_sda_quiet_r14: assert property (@(posedge clk) disable iff (!rstN)
    (scl && $past(scl)) |-> $stable(sdaPullLow));

  p_nv_needs_wel_r9: assert property (@(posedge clk) disable iff (!rstN)
    nvStoreReq |-> welFlag);

  p_wel_by_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(welFlag) |-> regWrStrobe);

  p_bias_by_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(biasTap) |-> regWrStrobe);

  p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    regWrStrobe |=> !regWrStrobe);
endmodule

bind biasI2cSlave biasI2cChecker #(.BIAS_W(BIAS_W)) chk_i (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaPullLow(sdaPullLow),
  .welFlag(welFlag), .biasTap(biasTap), .regWrStrobe(regWrStrobe),
  .nvStoreReq(nvStoreReq)
);

// File: tb/biasI2cSlave_tb_top.sv
`timescale 1ns/1ps
module biasI2cSlave_tb_top;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b0101, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b0101, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic nvBusy = 1'b0;
  logic stShutdown = 1'b1, stDirection = 1'b0, stEnable = 1'b1;
  logic sdaPullLow, gainSel, welFlag, regWrStrobe, regRdStrobe, nvStoreReq;
  logic [7:0] biasTap, strobeAddr;
  logic [5:0] refTap;
  logic line;

  always #4 clk = ~clk;
  assign line = sdaM && !sdaPullLow;

  biasI2cSlave dut_i (
    .clk(clk), .rstN(rstN), .scl(sclM), .sda(line), .sdaPullLow(sdaPullLow),
    .devAddr(STRAP), .nvBusy(nvBusy), .stShutdown(stShutdown),
    .stDirection(stDirection), .stEnable(stEnable), .biasTap(biasTap),
    .refTap(refTap), .gainSel(gainSel), .welFlag(welFlag),
    .regWrStrobe(regWrStrobe), .regRdStrobe(regRdStrobe),
    .strobeAddr(strobeAddr), .nvStoreReq(nvStoreReq)
  );

  int nChecks = 0, nFail = 0;
  logic done = 1'b0;
  logic quiet = 1'b0;
  logic [7:0] expBias = 0;
  logic [5:0] expRef = 0;
  logic expWel = 0, expGain = 0;
  int expWr = 0, expNv = 0, obsWr = 0, obsNv = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    expWr++;
    case (a)
      8'h00: begin expBias = d; if (expWel) expNv++; end
      8'h01: begin expRef = d[5:0]; if (expWel) expNv++; end
      8'h0F: begin expWel = d[1]; expGain = d[0]; end
      default: ;
    endcase
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (regWrStrobe) obsWr++;
      if (nvStoreReq) obsNv++;
    end
    if (rstN && quiet) begin
      chk(biasTap == expBias, "R2 bias register", biasTap, expBias);
      chk(refTap == expRef, "R3 reference register", refTap, expRef);
      chk(welFlag == expWel && gainSel == expGain, "R8 status bits",
          {welFlag, gainSel}, {expWel, expGain});
      chk(obsWr == expWr, "R2 write strobe count", obsWr, expWr);
      chk(obsNv == expNv, "R9 store request count", obsNv, expNv);
    end
  end

  task automatic waitC(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startC();
    quiet = 1'b0;
    waitC(2); sdaM = 1'b1; waitC(Q); sclM = 1'b1; waitC(Q);
    sdaM = 1'b0; waitC(Q); sclM = 1'b0;
  endtask

  task automatic stopC();
    waitC(2); sdaM = 1'b0; waitC(Q); sclM = 1'b1; waitC(Q);
    sdaM = 1'b1; waitC(2 * Q);
    quiet = 1'b1;
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      waitC(2); sdaM = b[i]; waitC(Q); sclM = 1'b1; waitC(2 * Q); sclM = 1'b0;
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    sendBits(b, 8);
    waitC(2); sdaM = 1'b1; waitC(Q); sclM = 1'b1; waitC(Q);
    ackd = !line;
    waitC(Q); sclM = 1'b0;
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitC(2); sdaM = 1'b1; waitC(Q); sclM = 1'b1; waitC(Q);
      b = {b[6:0], line};
      waitC(Q); sclM = 1'b0;
    end
    waitC(2); sdaM = !masterAck; waitC(Q); sclM = 1'b1; waitC(2 * Q); sclM = 1'b0;
    waitC(2); sdaM = 1'b1;
  endtask

  task automatic writeTx(input logic [7:0] a, input int n, input logic [7:0] d0,
                         input logic [7:0] d1, input string tag);
    logic ackd;
    logic [7:0] loc;
    loc = a;
    startC();
    sendByte(DEVW, ackd); chk(ackd, {tag, " slave byte ack"}, ackd, 1);
    sendByte(a, ackd); chk(ackd, {tag, " location ack"}, ackd, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(k == 0 ? d0 : d1, ackd);
      chk(ackd, {tag, " data ack"}, ackd, 1);
      modelWrite(loc, k == 0 ? d0 : d1);
      loc = loc + 8'd1;
    end
    stopC();
  endtask

  task automatic readTx(input int n, input logic [7:0] e0, input logic [7:0] e1,
                        input logic [7:0] e2, input string tag);
    logic ackd;
    logic [7:0] got, exp;
    startC();
    sendByte(DEVR, ackd); chk(ackd, {tag, " read slave ack"}, ackd, 1);
    for (int k = 0; k < n; k++) begin
      exp = (k == 0) ? e0 : (k == 1) ? e1 : e2;
      recvByte(k != n - 1, got);
      chk(got == exp, {tag, " read data"}, got, exp);
    end
    chk(!sdaPullLow, "R13 released after NACK", sdaPullLow, 0);
    stopC();
  endtask

  initial begin
    logic ackd;
    waitC(5); rstN = 1'b1; waitC(5);
    chk(biasTap == 0 && refTap == 0 && !welFlag && !gainSel, "R8 reset state",
        {biasTap, refTap, welFlag, gainSel}, 0);
    chk(!sdaPullLow, "R14 idle release", sdaPullLow, 0);
    quiet = 1'b1;
    waitC(20);

    // R2, R9: bias write with write-enable clear, no store request
    writeTx(8'h00, 1, 8'h5A, 8'h00, "R2");
    // R3: reference keeps six bits
    writeTx(8'h01, 1, 8'hFF, 8'h00, "R3");
    // R6: location-only write then current-location reads
    startC(); sendByte(DEVW, ackd); chk(ackd, "R6 slave ack", ackd, 1);
    sendByte(8'h01, ackd); chk(ackd, "R6 location ack", ackd, 1); stopC();
    readTx(1, 8'h3F, 8'h00, 8'h00, "R3 R6");
    readTx(1, 8'h00, 8'h00, 8'h00, "R11 R6 reserved");

    // R1: wrong identifier and wrong strap bits
    startC(); sendByte({4'b0110, STRAP, 1'b0}, ackd);
    chk(!ackd, "R1 wrong identifier", ackd, 0); stopC();
    startC(); sendByte({4'b0101, 3'b010, 1'b0}, ackd);
    chk(!ackd, "R1 wrong strap", ackd, 0); stopC();

    // R8, R10: set write enable, second data byte refused
    startC(); sendByte(DEVW, ackd); chk(ackd, "R10 slave ack", ackd, 1);
    sendByte(8'h0F, ackd); chk(ackd, "R10 location ack", ackd, 1);
    sendByte(8'h02, ackd); chk(ackd, "R8 status data ack", ackd, 1);
    modelWrite(8'h0F, 8'h02);
    sendByte(8'h01, ackd); chk(!ackd, "R10 second byte NACK", ackd, 0);
    stopC();

    // R9: store request with write enable set
    writeTx(8'h00, 1, 8'h33, 8'h00, "R9");

    // R4: stop after half a data byte
    startC(); sendByte(DEVW, ackd); sendByte(8'h00, ackd);
    sendBits(8'hFF, 4); stopC();
    chk(biasTap == 8'h33, "R4 aborted write", biasTap, 8'h33);

    // R5: busy store engine
    nvBusy = 1'b1;
    startC(); sendByte(DEVW, ackd); chk(!ackd, "R5 busy NACK", ackd, 0); stopC();
    nvBusy = 1'b0;
    writeTx(8'h01, 1, 8'h15, 8'h00, "R5 after busy");

    // R12: sequential data bytes
    writeTx(8'h00, 2, 8'h81, 8'h07, "R12");
    chk(refTap == 6'h07, "R12 second location", refTap, 7);

    // R11: reserved location write
    writeTx(8'h05, 1, 8'hAA, 8'h00, "R11");

    // R7, R8: status layout
    writeTx(8'h0F, 1, 8'h03, 8'h00, "R8");
    startC(); sendByte(DEVW, ackd); sendByte(8'h0F, ackd); stopC();
    readTx(1, 8'h93, 8'h00, 8'h00, "R7");
    writeTx(8'h0F, 1, 8'h00, 8'h00, "R8 clear");
    writeTx(8'h00, 1, 8'h44, 8'h00, "R9 disabled");

    // R13, R6: multi-byte read with pointer advance
    startC(); sendByte(DEVW, ackd); sendByte(8'h00, ackd); stopC();
    readTx(3, 8'h44, 8'h07, 8'h00, "R13");

    waitC(20);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule